// File: doc/BRIEF.md
# Serial Command Port Resynchronizer

This block sits at the front of a byte-wide serial command port. It samples the serial clock, data and active-low chip select in the system clock domain and assembles bytes MSB first. It hands each byte to the command decoder over a valid/ready stream. While doing so it looks for the alignment-recovery pattern. That pattern is a run of at least fifteen all-ones bytes closed by the byte 0xFE. When it sees the pattern, it emits a one-cycle restart pulse that sends the decoder back to waiting for a command. Resynchronisation changes no register value.

The block also owns the 32-bit configuration register and its software-reset handshake. Writing a 1 to bit 29 starts a reset sequence. For a fixed number of cycles the register returns to its default and a reset-active pin tells the rest of the chip to load its defaults. When the sequence ends, bit 28 (reset-done flag) is set. Reading the register clears that flag, so a host can tell a later reset from an earlier one.

Stream rules: `cmd_valid` stays high and `cmd_data` stays stable until `cmd_ready` is seen high at a clock edge. The serial link cannot be stalled. If a newer byte completes while one is still waiting, the newer byte replaces it. The consumer is therefore expected to accept each byte within one serial byte time.

Top module: `cmdport_resync`

## Requirements
- R1: While chip select is low, bits are taken on each serial-clock rising edge, most significant bit first. Every eight bits give one byte on the command stream.
- R2: Chip select going high in the middle of a byte throws away the partial byte and clears the bit position. The next byte starts with the first rising edge after chip select goes low again.
- R3: Fifteen or more consecutive 0xFF bytes followed by 0xFE produce exactly one single-cycle `dec_restart` pulse. The 0xFE that closes the run is not forwarded, while the 0xFF bytes are forwarded as usual.
- R4: A run of fewer than fifteen 0xFF bytes followed by 0xFE causes no restart, and that 0xFE is forwarded as an ordinary byte.
- R5: The count of consecutive 0xFF bytes saturates rather than wrapping, so a run of twenty 0xFF bytes followed by 0xFE still restarts. Any byte other than 0xFF ends the run.
- R6: A resynchronisation leaves the configuration register contents unchanged.
- R7: `cmd_valid` stays high with `cmd_data` stable until the byte is accepted. A byte that completes while an earlier one is still waiting replaces it.
- R8: A configuration write with bit 29 set starts a reset that lasts RST_CYCLES cycles. During that time `soft_reset_active` is high, the register holds its default value, and the other bits of that write are ignored. Writes that arrive during the reset are also ignored.
- R9: Bit 29 reads 1 while the reset is in progress. At the end of the reset the register reads its default value with bit 28 set.
- R10: A read (`cfg_rd` high for one cycle) clears bit 28 from the next cycle on.
- R11: A write with bit 29 clear updates every bit except bits 28 and 29. Bit 28 is never changed by a write.
- R12: After `rst_n` reset, the register reads the default (0 by default), and neither `cmd_valid` nor `dec_restart` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock, sampled by clk |
| spi_sdi | input | 1 | Serial data in |
| cmd_valid | output | 1 | A byte is waiting for the decoder |
| cmd_ready | input | 1 | Decoder accepts the waiting byte |
| cmd_data | output | 8 | Byte delivered to the decoder |
| dec_restart | output | 1 | One-cycle pulse: decoder must expect a new command |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe (clears reset-done flag) |
| cfg_rdata | output | 32 | Configuration register value |
| soft_reset_active | output | 1 | High while the software reset is in progress |

## Verification
The stream assertion assumes that, while a byte waits unaccepted, no newer byte has just been completed in that cycle. It is qualified on that event, and the stimulus holds `cmd_ready` low for only short stretches. The reset assertions assume that configuration reads and writes are single-cycle strobes that never coincide with the last cycle of a reset. The bench issues them only while the reset is idle, or on purpose early inside it. Serial stimulus keeps each serial-clock phase several system clocks long, so every edge survives the input synchronisers.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = 32;

  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] TERM_BYTE = 8'hFE;

  localparam int RST_REQ_BIT  = 29;
  localparam int RST_DONE_BIT = 28;

  localparam logic [CFG_W-1:0] HW_BITS =
    (CFG_W'(1) << RST_REQ_BIT) | (CFG_W'(1) << RST_DONE_BIT);
  localparam logic [CFG_W-1:0] SW_MASK = ~HW_BITS;

  typedef enum logic [0:0] {
    RST_IDLE = 1'b0,
    RST_BUSY = 1'b1
  } rst_state_e;
endpackage

// File: rtl/cpr_input_sync.sv
module cpr_input_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpr_byte_rx.sv
module cpr_byte_rx
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_d;
  logic [CNT_W-1:0]  bit_pos;
  logic [BYTE_W-2:0] shreg;
  logic              rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      bit_pos  <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      byte_stb <= 1'b0;
      if (csn_s) begin
        bit_pos <= '0;
        shreg   <= '0;
      end else if (rise) begin
        if (bit_pos == CNT_W'(BYTE_W-1)) begin
          byte_q   <= {shreg, sdi_s};
          byte_stb <= 1'b1;
          bit_pos  <= '0;
        end else begin
          shreg   <= {shreg[BYTE_W-3:0], sdi_s};
          bit_pos <= bit_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpr_run_detect.sv
module cpr_run_detect
  import cmdport_pkg::*;
#(
  parameter int RUN_MIN = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              fwd_stb,
  output logic              restart
);
  localparam int RUN_W = $clog2(RUN_MIN + 1);

  logic [RUN_W-1:0] run_cnt;
  logic             run_full;
  logic             is_fill;
  logic             is_term;
  logic             hit;

  assign run_full = (run_cnt == RUN_W'(RUN_MIN));
  assign is_fill  = (byte_q == FILL_BYTE);
  assign is_term  = (byte_q == TERM_BYTE);
  assign hit      = byte_stb & is_term & run_full;
  assign fwd_stb  = byte_stb & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      restart <= 1'b0;
    end else begin
      restart <= hit;
      if (byte_stb) begin
        if (is_fill) begin
          if (!run_full) run_cnt <= run_cnt + 1'b1;
        end else begin
          run_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cpr_cfg_reset.sv
module cpr_cfg_reset
  import cmdport_pkg::*;
#(
  parameter int               RST_CYCLES  = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             rd,
  output logic [CFG_W-1:0] rdata,
  output logic             busy
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CFG_W-1:0] DEF_SW = CFG_DEFAULT & SW_MASK;
  localparam logic [CFG_W-1:0] DONE_M = CFG_W'(1) << RST_DONE_BIT;

  rst_state_e       state;
  logic [CW-1:0]    cnt;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_n;
  logic             start;

  assign start = (state == RST_IDLE) && wr && wdata[RST_REQ_BIT];
  assign busy  = (state == RST_BUSY);
  assign rdata = cfg_q | (CFG_W'(busy) << RST_REQ_BIT);

  always_comb begin
    cfg_n = cfg_q;
    if (state == RST_BUSY) begin
      if (cnt == '0) cfg_n = DEF_SW | DONE_M;
    end else if (start) begin
      cfg_n = DEF_SW;
    end else begin
      if (wr) cfg_n = (wdata & SW_MASK) | (cfg_q & ~SW_MASK);
      if (rd) cfg_n = cfg_n & ~DONE_M;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RST_IDLE;
      cnt   <= '0;
      cfg_q <= DEF_SW;
    end else begin
      cfg_q <= cfg_n;
      if (state == RST_BUSY) begin
        if (cnt == '0) state <= RST_IDLE;
        else           cnt   <= cnt - 1'b1;
      end else if (start) begin
        state <= RST_BUSY;
        cnt   <= CW'(RST_CYCLES - 1);
      end
    end
  end
endmodule

// File: rtl/cmdport_resync.sv
module cmdport_resync
  import cmdport_pkg::*;
#(
  parameter int               RUN_MIN     = 15,
  parameter int               SYNC_STAGES = 2,
  parameter int               RST_CYCLES  = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              dec_restart,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_rd,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              soft_reset_active
);
  logic [2:0]        pins_s;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;
  logic              fwd_stb;

  cpr_input_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_sdi}),
    .q     (pins_s)
  );

  cpr_byte_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .byte_stb (byte_stb),
    .byte_q   (byte_q)
  );

  cpr_run_detect #(
    .RUN_MIN (RUN_MIN)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (byte_stb),
    .byte_q   (byte_q),
    .fwd_stb  (fwd_stb),
    .restart  (dec_restart)
  );

  cpr_cfg_reset #(
    .RST_CYCLES  (RST_CYCLES),
    .CFG_DEFAULT (CFG_DEFAULT)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rd    (cfg_rd),
    .rdata (cfg_rdata),
    .busy  (soft_reset_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (fwd_stb) begin
      cmd_valid <= 1'b1;
      cmd_data  <= byte_q;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdport_resync_chk.sv
module cmdport_resync_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_data,
  input logic        dec_restart,
  input logic        fwd_stb,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_rd,
  input logic [31:0] cfg_rdata,
  input logic        soft_reset_active
);
  // R3: restart is a single-cycle pulse
  assert_restart_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_restart |=> !dec_restart);

  // R7: waiting byte is held until accepted unless replaced
  assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !fwd_stb) |=> (cmd_valid && $stable(cmd_data)));

  // R8: reset sequence only starts from a write with bit 29 set
  assert_reset_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_reset_active) |-> $past(cfg_wr && cfg_wdata[29]));

  // R9: reset-done flag only appears at the end of a reset sequence
  assert_done_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[28]) |-> $past(soft_reset_active));

  // R10: a read clears the reset-done flag
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_rd) && $past(cfg_rdata[28]) && !$past(soft_reset_active))
      |-> !cfg_rdata[28]);
endmodule

bind cmdport_resync cmdport_resync_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_valid         (cmd_valid),
  .cmd_ready         (cmd_ready),
  .cmd_data          (cmd_data),
  .dec_restart       (dec_restart),
  .fwd_stb           (fwd_stb),
  .cfg_wr            (cfg_wr),
  .cfg_wdata         (cfg_wdata),
  .cfg_rd            (cfg_rd),
  .cfg_rdata         (cfg_rdata),
  .soft_reset_active (soft_reset_active)
);

// File: tb/tb_cmdport_resync.sv
`timescale 1ns/1ps
module tb_cmdport_resync;
  localparam int RST_CYCLES = 8;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [7:0]  cmd_data;
  logic        dec_restart;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        soft_reset_active;

  int checks = 0, errors = 0;
  int log_n = 0, restarts = 0;
  logic [7:0] log_b [0:255];

  always #5 clk = ~clk;

  cmdport_resync #(.RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .dec_restart(dec_restart), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .soft_reset_active(soft_reset_active)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ready && log_n < 256) begin
        log_b[log_n] = cmd_data;
        log_n++;
      end
      if (dec_restart) restarts++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sclk = 1'b0; wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic settle;
    wait_clk(12);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic t_reset_state;
    check(cfg_rdata == 32'h0, "R12 cfg", cfg_rdata, 0);
    check(cmd_valid == 1'b0, "R12 valid", cmd_valid, 0);
    check(dec_restart == 1'b0 && restarts == 0, "R12 restart", restarts, 0);
  endtask

  task automatic t_bytes;
    int n0 = log_n;
    send_byte(8'hA5); send_byte(8'h3C); settle();
    check(log_n == n0 + 2, "R1 count", log_n - n0, 2);
    check(log_b[n0] == 8'hA5, "R1 first", log_b[n0], 8'hA5);
    check(log_b[n0+1] == 8'h3C, "R1 second", log_b[n0+1], 8'h3C);
  endtask

  task automatic t_cs_abort;
    int n0 = log_n;
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    wait_clk(2); cs_n = 1'b1; wait_clk(10);
    send_byte(8'h5A); settle();
    check(log_n == n0 + 1, "R2 count", log_n - n0, 1);
    check(log_b[n0] == 8'h5A, "R2 data", log_b[n0], 8'h5A);
  endtask

  task automatic t_resync;
    int n0, r0;
    bit all_ff = 1'b1;
    cfg_write(32'h0000_1234);
    n0 = log_n; r0 = restarts;
    for (int i = 0; i < 15; i++) send_byte(8'hFF);
    send_byte(8'hFE); settle();
    check(restarts == r0 + 1, "R3 restart", restarts - r0, 1);
    check(log_n == n0 + 15, "R3 forwarded", log_n - n0, 15);
    for (int i = 0; i < 15; i++) if (log_b[n0+i] != 8'hFF) all_ff = 1'b0;
    check(all_ff, "R3 fill bytes", all_ff, 1);
    check(cfg_rdata == 32'h0000_1234, "R6 cfg kept", cfg_rdata, 32'h1234);
  endtask

  task automatic t_short_run;
    int n0 = log_n, r0 = restarts;
    for (int i = 0; i < 14; i++) send_byte(8'hFF);
    send_byte(8'hFE); settle();
    check(restarts == r0, "R4 no restart", restarts - r0, 0);
    check(log_n == n0 + 15, "R4 forwarded", log_n - n0, 15);
    check(log_b[n0+14] == 8'hFE, "R4 term kept", log_b[n0+14], 8'hFE);
  endtask

  task automatic t_saturate;
    int r0 = restarts;
    for (int i = 0; i < 20; i++) send_byte(8'hFF);
    send_byte(8'hFE); settle();
    check(restarts == r0 + 1, "R5 long run", restarts - r0, 1);
    r0 = restarts;
    for (int i = 0; i < 10; i++) send_byte(8'hFF);
    send_byte(8'h00);
    for (int i = 0; i < 10; i++) send_byte(8'hFF);
    send_byte(8'hFE); settle();
    check(restarts == r0, "R5 broken run", restarts - r0, 0);
  endtask

  task automatic t_stream;
    int n0 = log_n;
    cmd_ready = 1'b0;
    send_byte(8'h11); settle();
    check(cmd_valid && cmd_data == 8'h11, "R7 held", cmd_data, 8'h11);
    wait_clk(5);
    check(cmd_valid && cmd_data == 8'h11, "R7 stable", cmd_data, 8'h11);
    send_byte(8'h22); settle();
    check(cmd_data == 8'h22, "R7 replaced", cmd_data, 8'h22);
    cmd_ready = 1'b1; wait_clk(2);
    check(log_n == n0 + 1 && log_b[n0] == 8'h22, "R7 accept", log_b[n0], 8'h22);
    check(!cmd_valid, "R7 drained", cmd_valid, 0);
  endtask

  task automatic t_cfg_write;
    cfg_write(32'h1000_00A5); wait_clk(1);
    check(cfg_rdata == 32'h0000_00A5, "R11 write", cfg_rdata, 32'hA5);
  endtask

  task automatic t_soft_reset;
    int n = 0;
    cfg_write(32'h2000_0055);
    check(cfg_rdata == 32'h2000_0000, "R9 busy read", cfg_rdata, 32'h2000_0000);
    while (soft_reset_active && n < 100) begin
      n++;
      cfg_wr = (n == 2); cfg_wdata = 32'h0000_00FF;
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    check(n == RST_CYCLES, "R8 length", n, RST_CYCLES);
    check(cfg_rdata == 32'h1000_0000, "R9 done", cfg_rdata, 32'h1000_0000);
    check(cfg_rdata[7:0] == 8'h00, "R8 ignored bits", cfg_rdata[7:0], 0);
  endtask

  task automatic t_read_clear;
    @(negedge clk); cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0;
    check(cfg_rdata[28] == 1'b0, "R10 cleared", cfg_rdata[28], 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset_state();
    t_bytes();
    t_cs_abort();
    t_cfg_write();
    t_resync();
    t_short_run();
    t_saturate();
    t_stream();
    t_soft_reset();
    t_read_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule